// File: doc/BRIEF.md
# Wide-to-Narrow Bus Sizing Sequencer

This block sits between a 32-bit bus master and a slave port whose width is chosen at run time: 16 bits or 8 bits. The master issues one request at a time. A request is a byte, word or longword access, or a four-longword line fill. The sequencer turns each request into a series of narrow transfers. Each transfer carries its own address, byte-lane strobes and request/acknowledge handshake. Read pieces are gathered into a 32-bit word, and the master sees one completion pulse after the whole request has been served.

The data order is big-endian. The most significant part of the data goes first. The lowest address holds the most significant byte. Master data is right-justified: a byte sits in bits 7:0, a word in bits 15:0 and a longword in bits 31:0. A line fill is always carried out as four longword reads, and no bursting is used. On a 16-bit port the block does not support a word or longword at an odd address.

Top module: `narrow_bus_sequencer`

## Requirements
- R1: While `rst_n` is low, and after it is released with no request pending, `s_req`, `s_uds`, `s_lds`, `m_rvalid` and `m_done` are all 0.
- R2: With `mode_16`=1, a longword request at address A (`m_size`=2) makes two transfers, at A and then A+2. The first carries data bits 31:16 on `s_wdata[15:0]` and the second carries bits 15:0. Both strobes are high in each.
- R3: With `mode_16`=0, a word request (`m_size`=1) makes two transfers and a longword request makes four. The addresses are A, A+1, and so on, with the most significant byte first. Data travels on `s_wdata[7:0]` and `s_rdata[7:0]`. Only `s_lds` is asserted.
- R4: With `mode_16`=1, a byte request (`m_size`=0) makes one transfer. At an even address only `s_uds` is asserted and the byte travels on bits 15:8. At an odd address only `s_lds` is asserted and the byte travels on bits 7:0. A read returns the byte in `m_rdata[7:0]` with the upper bits zero. A word request makes a single transfer with both strobes high.
- R5: A line fill (`m_size`=3) makes 8 transfers at A+2k on a 16-bit port, or 16 transfers at A+k on an 8-bit port. Each transfer is a read (`s_we`=0) whatever the value of `m_we`. The four longwords appear in address order on `m_rdata`, one `m_rvalid` pulse each.
- R6: `m_done` is high for exactly one cycle, the cycle after the final `s_ack`. On reads, `m_rvalid` and the assembled `m_rdata` are presented in that cycle. Writes never raise `m_rvalid`.
- R7: `s_req` stays high with `s_addr` and the strobes stable until `s_ack` is seen, for any number of cycles. `s_req` drops for one cycle after every acknowledge.
- R8: `m_req` is ignored while a request is in progress, so no extra transfers follow the current request.
- R9: `mode_16` is sampled when a request is accepted. Changing it during a request does not alter that request's transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_16 | input | 1 | Port width: 1 = 16-bit, 0 = 8-bit |
| m_req | input | 1 | Master request, taken when the block is idle |
| m_we | input | 1 | Master write (1) or read (0) |
| m_size | input | 2 | 0 byte, 1 word, 2 longword, 3 line fill |
| m_addr | input | ADDR_W | Request byte address |
| m_wdata | input | 32 | Right-justified write data |
| m_rdata | output | 32 | Assembled read data |
| m_rvalid | output | 1 | One-cycle pulse per completed read longword |
| m_done | output | 1 | One-cycle completion pulse |
| s_req | output | 1 | Narrow transfer request |
| s_we | output | 1 | Narrow transfer write |
| s_addr | output | ADDR_W | Narrow transfer byte address |
| s_uds | output | 1 | Upper byte-lane strobe |
| s_lds | output | 1 | Lower byte-lane strobe |
| s_wdata | output | 16 | Narrow write data |
| s_rdata | input | 16 | Narrow read data |
| s_ack | input | 1 | Slave acknowledge for the current transfer |

## Verification
A request pulse is taken at one rising edge, and the first `s_req` appears after that same edge. `s_req` remains high until the edge that samples `s_ack`; it is then low for one cycle before the next piece. `m_done`, `m_rvalid` and `m_rdata` are registered, so they are due exactly one cycle after the edge that sampled the final acknowledge. The bench drives `s_ack` and samples all outputs on the falling edge. It records the cycle of each acknowledge it gives and checks that completion arrives on the falling edge that follows. It also checks that `m_done` is low again one cycle later.

// File: rtl/nseq_pkg.sv
`timescale 1ns/1ps
package nseq_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LINE = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } seq_state_e;

  localparam int unsigned MAX_PIECES = 16;
  localparam int unsigned CNT_W      = $clog2(MAX_PIECES);

  // bytes moved by one narrow transfer
  function automatic logic [1:0] lane_bytes(acc_size_e sz, logic wide);
    return (sz != SZ_BYTE && wide) ? 2'd2 : 2'd1;
  endfunction

  // transfers per longword (or per shorter access)
  function automatic logic [2:0] unit_pieces(acc_size_e sz, logic wide);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_WORD: return wide ? 3'd1 : 3'd2;
      default: return wide ? 3'd2 : 3'd4;
    endcase
  endfunction

  // transfers in the whole request
  function automatic logic [4:0] total_pieces(acc_size_e sz, logic wide);
    case (sz)
      SZ_BYTE: return 5'd1;
      SZ_WORD: return wide ? 5'd1 : 5'd2;
      SZ_LONG: return wide ? 5'd2 : 5'd4;
      default: return wide ? 5'd8 : 5'd16;
    endcase
  endfunction

  // position of a piece inside its longword
  function automatic logic [1:0] unit_index(logic [CNT_W-1:0] cnt, logic [2:0] unit);
    return cnt[1:0] & 2'(unit - 3'd1);
  endfunction

  // bit shift of a piece in right-justified data; first piece is most significant
  function automatic logic [4:0] lane_shift(logic [2:0] unit, logic [1:0] j, logic [1:0] bpp);
    logic [2:0] rem;
    logic [2:0] by;
    rem = unit - 3'd1 - {1'b0, j};
    by  = (bpp == 2'd2) ? {rem[1:0], 1'b0} : rem;
    return {by[1:0], 3'b000};
  endfunction

endpackage

// File: rtl/nseq_lane.sv
`timescale 1ns/1ps
module nseq_lane
  import nseq_pkg::*;
(
  input  acc_size_e          size,
  input  logic               wide,
  input  logic               addr_lsb,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [31:0]        wdata,
  input  logic [15:0]        s_rdata,
  output logic [15:0]        lane_wdata,
  output logic               uds,
  output logic               lds,
  output logic [31:0]        rd_place,
  output logic               unit_first,
  output logic               unit_last
);

  logic [2:0]  unit;
  logic [1:0]  bpp;
  logic [1:0]  j;
  logic [4:0]  sh;
  logic [31:0] wshift;
  logic [15:0] rchunk;

  always_comb begin
    unit   = unit_pieces(size, wide);
    bpp    = lane_bytes(size, wide);
    j      = unit_index(cnt, unit);
    sh     = lane_shift(unit, j, bpp);
    wshift = wdata >> sh;
    lane_wdata = (bpp == 2'd2) ? wshift[15:0] : {wshift[7:0], wshift[7:0]};

    if (bpp == 2'd2)      rchunk = s_rdata;
    else if (wide)        rchunk = addr_lsb ? {8'h00, s_rdata[7:0]} : {8'h00, s_rdata[15:8]};
    else                  rchunk = {8'h00, s_rdata[7:0]};
    rd_place = {16'h0000, rchunk} << sh;

    if (!wide) begin
      uds = 1'b0;
      lds = 1'b1;
    end else if (size == SZ_BYTE) begin
      uds = ~addr_lsb;
      lds = addr_lsb;
    end else begin
      uds = 1'b1;
      lds = 1'b1;
    end

    unit_first = (j == 2'd0);
    unit_last  = ({1'b0, j} == unit - 3'd1);
  end

endmodule

// File: rtl/nseq_assemble.sv
`timescale 1ns/1ps
module nseq_assemble #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          unit_first,
  input  logic          unit_last,
  input  logic [DW-1:0] rd_place,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  logic [DW-1:0] hold_q;
  logic [DW-1:0] next_hold;

  assign next_hold = (unit_first ? '0 : hold_q) | rd_place;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= capture && unit_last;
      if (capture) hold_q <= next_hold;
      if (capture && unit_last) rdata <= next_hold;
    end
  end

  // R6
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

endmodule

// File: rtl/narrow_bus_sequencer.sv
`timescale 1ns/1ps
module narrow_bus_sequencer
  import nseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_16,
  input  logic              m_req,
  input  logic              m_we,
  input  logic [1:0]        m_size,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [31:0]       m_wdata,
  output logic [31:0]       m_rdata,
  output logic              m_rvalid,
  output logic              m_done,
  output logic              s_req,
  output logic              s_we,
  output logic [ADDR_W-1:0] s_addr,
  output logic              s_uds,
  output logic              s_lds,
  output logic [15:0]       s_wdata,
  input  logic [15:0]       s_rdata,
  input  logic              s_ack
);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] base_q;
  acc_size_e         size_q;
  logic              we_q;
  logic              wide_q;
  logic [31:0]       wdata_q;
  logic              done_q;

  // named events for checks
  logic              accept;
  logic              piece_ack;
  logic              last_piece;
  logic [4:0]        total;
  logic [ADDR_W-1:0] piece_off;
  logic              lane_uds, lane_lds;
  logic [31:0]       rd_place;
  logic              unit_first, unit_last;

  assign accept     = (state_q == ST_IDLE) && m_req;
  assign total      = total_pieces(size_q, wide_q);
  assign last_piece = ({1'b0, cnt_q} == total - 5'd1);
  assign piece_ack  = (state_q == ST_XFER) && s_ack;
  assign piece_off  = (lane_bytes(size_q, wide_q) == 2'd2) ? ADDR_W'({cnt_q, 1'b0})
                                                           : ADDR_W'(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      base_q  <= '0;
      size_q  <= SZ_BYTE;
      we_q    <= 1'b0;
      wide_q  <= 1'b0;
      wdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= piece_ack && last_piece;
      case (state_q)
        ST_IDLE: if (accept) begin
          base_q  <= m_addr;
          size_q  <= acc_size_e'(m_size);
          we_q    <= m_we && (acc_size_e'(m_size) != SZ_LINE);
          wide_q  <= mode_16;
          wdata_q <= m_wdata;
          cnt_q   <= '0;
          state_q <= ST_XFER;
        end
        ST_XFER: if (s_ack) begin
          if (last_piece) state_q <= ST_IDLE;
          else begin
            cnt_q   <= cnt_q + 1'b1;
            state_q <= ST_GAP;
          end
        end
        ST_GAP:  state_q <= ST_XFER;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  nseq_lane u_lane (
    .size       (size_q),
    .wide       (wide_q),
    .addr_lsb   (s_addr[0]),
    .cnt        (cnt_q),
    .wdata      (wdata_q),
    .s_rdata    (s_rdata),
    .lane_wdata (s_wdata),
    .uds        (lane_uds),
    .lds        (lane_lds),
    .rd_place   (rd_place),
    .unit_first (unit_first),
    .unit_last  (unit_last)
  );

  nseq_assemble #(.DW(32)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (piece_ack && !we_q),
    .unit_first (unit_first),
    .unit_last  (unit_last),
    .rd_place   (rd_place),
    .rdata      (m_rdata),
    .rvalid     (m_rvalid)
  );

  assign s_req  = (state_q == ST_XFER);
  assign s_we   = we_q;
  assign s_addr = base_q + piece_off;
  assign s_uds  = s_req && lane_uds;
  assign s_lds  = s_req && lane_lds;
  assign m_done = done_q;

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_req && !s_ack |=> s_req && $stable(s_addr) && $stable(s_uds) && $stable(s_lds));

  // R7
  ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_req && s_ack |=> !s_req);

  // R6
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_done |-> $past(s_req && s_ack));

  // R3
  narrow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_req && !wide_q |-> s_lds && !s_uds);

  // R4
  byte_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_req && wide_q && size_q == SZ_BYTE |-> $countones({s_uds, s_lds}) == 1);

  // R5
  line_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_req && size_q == SZ_LINE |-> !s_we);

  // R5
  piece_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_req |-> {1'b0, cnt_q} < total);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != ST_IDLE && m_req |=> $stable(base_q) && $stable(size_q));

endmodule

// File: tb/narrow_bus_sequencer_tb.sv
`timescale 1ns/1ps
module narrow_bus_sequencer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_16 = 1'b1;
  logic        m_req = 1'b0;
  logic        m_we = 1'b0;
  logic [1:0]  m_size = 2'd0;
  logic [31:0] m_addr = '0;
  logic [31:0] m_wdata = '0;
  logic [31:0] m_rdata;
  logic        m_rvalid, m_done;
  logic        s_req, s_we, s_uds, s_lds;
  logic [31:0] s_addr;
  logic [15:0] s_wdata;
  logic [15:0] s_rdata = '0;
  logic        s_ack = 1'b0;

  always #10 clk = ~clk;

  narrow_bus_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .mode_16(mode_16), .m_req(m_req), .m_we(m_we),
    .m_size(m_size), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .m_rvalid(m_rvalid), .m_done(m_done), .s_req(s_req), .s_we(s_we),
    .s_addr(s_addr), .s_uds(s_uds), .s_lds(s_lds), .s_wdata(s_wdata),
    .s_rdata(s_rdata), .s_ack(s_ack)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, last_ack_cyc = -10, dt_err = 0;
  int lat = 0, wcnt = 0;
  bit port16 = 1'b1;
  bit done_seen = 1'b0;
  int log_n = 0, rv_n = 0;
  logic [31:0] log_addr [0:31];
  logic [15:0] log_wd   [0:31];
  logic        log_we   [0:31];
  logic        log_uds  [0:31];
  logic        log_lds  [0:31];
  logic [31:0] rv_data  [0:3];

  function automatic logic [7:0] bval(input logic [31:0] a);
    return (a[7:0] * 8'd7) ^ 8'h3C;
  endfunction

  function automatic logic [31:0] exp_long(input logic [31:0] a);
    return {bval(a), bval(a + 1), bval(a + 2), bval(a + 3)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // slave model and monitor, all on the falling edge
  always @(negedge clk) begin
    logic [31:0] e;
    cyc++;
    if (m_rvalid && rv_n < 4) begin rv_data[rv_n] = m_rdata; rv_n++; end
    if (m_done) begin
      done_seen = 1'b1;
      if (cyc != last_ack_cyc + 1) dt_err++;
    end
    if (s_ack) s_ack = 1'b0;
    else if (s_req) begin
      if (wcnt >= lat) begin
        s_ack = 1'b1;
        wcnt = 0;
        last_ack_cyc = cyc;
        if (port16) begin
          e = {s_addr[31:1], 1'b0};
          s_rdata = {bval(e), bval(e + 1)};
        end else s_rdata = {8'hEE, bval(s_addr)};
        if (log_n < 32) begin
          log_addr[log_n] = s_addr; log_wd[log_n] = s_wdata; log_we[log_n] = s_we;
          log_uds[log_n] = s_uds;   log_lds[log_n] = s_lds;
          log_n++;
        end
      end else wcnt++;
    end
  end

  task automatic start(input logic [31:0] a, input logic [1:0] sz, input bit we,
                       input logic [31:0] wd, input bit p16, input int l);
    port16 = p16; lat = l; wcnt = 0;
    log_n = 0; rv_n = 0; done_seen = 1'b0; dt_err = 0;
    @(negedge clk);
    mode_16 = p16; m_addr = a; m_size = sz; m_we = we; m_wdata = wd; m_req = 1'b1;
    @(negedge clk);
    m_req = 1'b0;
  endtask

  task automatic finish_req(input string req);
    for (int i = 0; i < 3000; i++) begin
      #1;
      if (done_seen) break;
      @(negedge clk);
    end
    chk(done_seen, req, "completion seen", done_seen, 1);
    chk(dt_err == 0, "R6", "m_done one cycle after last ack", dt_err, 0);
    @(negedge clk); #1;
    chk(m_done == 1'b0, "R6", "m_done single cycle", m_done, 0);
  endtask

  task automatic chk_seq(input string req, input int n, input logic [31:0] a, input int step,
                         input bit we, input bit uds, input bit lds);
    chk(log_n == n, req, "transfer count", log_n, n);
    for (int k = 0; k < n && k < log_n; k++) begin
      chk(log_addr[k] == a + k * step, req, "piece address", log_addr[k], a + k * step);
      chk(log_we[k] == we && log_uds[k] == uds && log_lds[k] == lds, req, "we/uds/lds",
          {log_we[k], log_uds[k], log_lds[k]}, {we, uds, lds});
    end
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk({s_req, s_uds, s_lds, m_rvalid, m_done} == 5'b0, "R1", "outputs in reset",
        {s_req, s_uds, s_lds, m_rvalid, m_done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk({s_req, s_uds, s_lds, m_rvalid, m_done} == 5'b0, "R1", "outputs idle",
        {s_req, s_uds, s_lds, m_rvalid, m_done}, 0);
  endtask

  task automatic t_long_write16;
    start(32'h100, 2'd2, 1'b1, 32'h11223344, 1'b1, 0);
    finish_req("R2");
    chk_seq("R2", 2, 32'h100, 2, 1'b1, 1'b1, 1'b1);
    chk(log_wd[0] == 16'h1122, "R2", "upper half first", log_wd[0], 16'h1122);
    chk(log_wd[1] == 16'h3344, "R2", "lower half second", log_wd[1], 16'h3344);
    chk(rv_n == 0, "R6", "no rvalid on write", rv_n, 0);
  endtask

  task automatic t_long_read16;
    start(32'h204, 2'd2, 1'b0, 0, 1'b1, 1);
    finish_req("R2");
    chk_seq("R2", 2, 32'h204, 2, 1'b0, 1'b1, 1'b1);
    chk(rv_n == 1 && rv_data[0] == exp_long(32'h204), "R6", "assembled longword",
        rv_data[0], exp_long(32'h204));
  endtask

  task automatic t_bytes16;
    start(32'h301, 2'd0, 1'b0, 0, 1'b1, 0);
    finish_req("R4");
    chk_seq("R4", 1, 32'h301, 1, 1'b0, 1'b0, 1'b1);
    chk(rv_data[0] == {24'h0, bval(32'h301)}, "R4", "odd byte read", rv_data[0], {24'h0, bval(32'h301)});
    start(32'h40A, 2'd0, 1'b1, 32'h000000C3, 1'b1, 2);
    finish_req("R4");
    chk_seq("R4", 1, 32'h40A, 1, 1'b1, 1'b1, 1'b0);
    chk(log_wd[0][15:8] == 8'hC3, "R4", "even byte on upper lane", log_wd[0][15:8], 8'hC3);
    start(32'h320, 2'd1, 1'b0, 0, 1'b1, 0);
    finish_req("R4");
    chk_seq("R4", 1, 32'h320, 1, 1'b0, 1'b1, 1'b1);
    chk(rv_data[0] == {16'h0, bval(32'h320), bval(32'h321)}, "R4", "word read",
        rv_data[0], {16'h0, bval(32'h320), bval(32'h321)});
  endtask

  task automatic t_narrow;
    start(32'h501, 2'd1, 1'b1, 32'h0000BEEF, 1'b0, 0);
    finish_req("R3");
    chk_seq("R3", 2, 32'h501, 1, 1'b1, 1'b0, 1'b1);
    chk(log_wd[0][7:0] == 8'hBE && log_wd[1][7:0] == 8'hEF, "R3", "word bytes msb first",
        {log_wd[0][7:0], log_wd[1][7:0]}, 16'hBEEF);
    start(32'h600, 2'd2, 1'b0, 0, 1'b0, 3);
    finish_req("R3");
    chk_seq("R3", 4, 32'h600, 1, 1'b0, 1'b0, 1'b1);
    chk(rv_data[0] == exp_long(32'h600), "R3", "narrow longword read", rv_data[0], exp_long(32'h600));
  endtask

  task automatic t_line(input bit p16);
    start(32'h1000, 2'd3, 1'b1, 32'hFFFFFFFF, p16, 0);
    finish_req("R5");
    if (p16) chk_seq("R5", 8, 32'h1000, 2, 1'b0, 1'b1, 1'b1);
    else     chk_seq("R5", 16, 32'h1000, 1, 1'b0, 1'b0, 1'b1);
    chk(rv_n == 4, "R5", "longwords delivered", rv_n, 4);
    for (int i = 0; i < 4 && i < rv_n; i++)
      chk(rv_data[i] == exp_long(32'h1000 + 4 * i), "R5", "line longword", rv_data[i],
          exp_long(32'h1000 + 4 * i));
  endtask

  task automatic t_busy;
    start(32'h600, 2'd2, 1'b0, 0, 1'b0, 2);
    @(negedge clk);
    m_addr = 32'h7777; m_size = 2'd3; m_req = 1'b1;
    @(negedge clk);
    m_req = 1'b0;
    finish_req("R8");
    repeat (10) @(negedge clk);
    chk_seq("R8", 4, 32'h600, 1, 1'b0, 1'b0, 1'b1);
    chk(rv_data[0] == exp_long(32'h600), "R8", "first request data", rv_data[0], exp_long(32'h600));
  endtask

  task automatic t_mode_flip;
    start(32'h880, 2'd2, 1'b0, 0, 1'b1, 2);
    mode_16 = 1'b0;
    finish_req("R9");
    chk_seq("R9", 2, 32'h880, 2, 1'b0, 1'b1, 1'b1);
    chk(rv_data[0] == exp_long(32'h880), "R9", "read unaffected by mode change",
        rv_data[0], exp_long(32'h880));
    mode_16 = 1'b1;
  endtask

  task automatic t_long_wait;
    start(32'h900, 2'd2, 1'b1, 32'hA1B2C3D4, 1'b1, 25);
    finish_req("R7");
    chk_seq("R7", 2, 32'h900, 2, 1'b1, 1'b1, 1'b1);
    chk(log_wd[1] == 16'hC3D4, "R7", "data held through long wait", log_wd[1], 16'hC3D4);
  endtask

  initial begin
    t_reset();
    t_long_write16();
    t_long_read16();
    t_bytes16();
    t_narrow();
    t_line(1'b1);
    t_line(1'b0);
    t_busy();
    t_mode_flip();
    t_long_wait();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule